// File: doc/BRIEF.md
# Memory-Space Peripheral Port Decoder with ROM Shadow Suppression

This block sits on an 8-bit CPU bus whose programming environment can only issue memory reads and writes. It claims a small window of memory space for peripheral ports. That window lies inside an area where a partly decoded ROM would otherwise answer as a mirror image. A memory request with the top three address bits equal to `001` (the 0x2000 region) hits the window. In eight-port mode, the low three address bits then pick one of eight active-low port enables (0x2000 to 0x2007). The address bits between the tag and the select field are not decoded, so the ports repeat across the region.

A build parameter selects single-port mode instead. In that mode only enable 0 exists in practice, and any address in the window drives it. The read and write strobes are forwarded to the ports as their other two control inputs.

While any port enable is active, the block drives the ROM chip-select line high so that the ROM mirror stays off the bus. At every other time it releases the line. The release is shown as a drive-enable output that is low, so the existing system logic keeps control of the ROM select. All outputs are registered and follow the bus inputs one clock later.

Top module: `mmio_port_decoder`

## Requirements
- R1: A port hit requires the memory request low and address bits 15, 14, 13 equal to 0, 0, 1. The same address with the memory request high, or with bit 13 low, or with bit 15 or 14 high, produces no hit.
- R2: In eight-port mode (SINGLE=0), a hit drives port_ce_n[addr[2:0]] low and holds every other enable high. Address bits 12..3 are ignored, so for example 0x3FF9 selects enable 1.
- R3: In single-port mode (SINGLE=1), a hit drives port_ce_n[0] low whatever address bits 12..0 hold, and enables 1..7 stay high.
- R4: Without a hit, all port enables are high.
- R5: While any port enable is low, romcs_drive_en is 1 and romcs_drive_val is 1, which holds the ROM deselected.
- R6: While all port enables are high, romcs_drive_en is 0, which releases the ROM select line.
- R7: port_rd_n and port_wr_n equal cpu_rd_n and cpu_wr_n from the previous clock, whether or not a port is hit.
- R8: The outputs are registered with one clock of latency. A synchronous active-high reset sets all enables high, both strobes high, romcs_drive_en to 0 and romcs_drive_val to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_mreq_n | input | 1 | Memory request, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| port_ce_n | output | 8 | Port chip enables, active low |
| port_rd_n | output | 1 | Registered read strobe for the ports |
| port_wr_n | output | 1 | Registered write strobe for the ports |
| romcs_drive_en | output | 1 | 1 = drive the ROM select line, 0 = release it |
| romcs_drive_val | output | 1 | Level driven onto the ROM select line (1 = deselect) |

## Verification
Every result of this block, whether an enable, a strobe or the ROM override, appears at the first rising edge after the bus inputs that cause it. The bench applies the inputs at a falling edge. It compares all outputs at the next falling edge, when the capturing register has loaded and before the next inputs are applied. Expected values come from bench functions of the last applied inputs. The properties use a one-clock implication for the same relation.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;
  // ROM select override: en=0 means released, val is level when driven
  typedef struct packed {
    logic en;
    logic val;
  } rom_ovr_t;

  localparam rom_ovr_t ROM_OVR_IDLE = '{en: 1'b0, val: 1'b1};
endpackage

// File: rtl/mmio_hit_match.sv
module mmio_hit_match #(
  parameter int TAG_W = 3,
  parameter logic [TAG_W-1:0] TAG = 3'b001
) (
  input  logic [TAG_W-1:0] tag_bits,
  input  logic             mreq_n,
  output logic             hit
);
  always_comb hit = !mreq_n && (tag_bits == TAG);
endmodule

// File: rtl/mmio_sel_decode.sv
module mmio_sel_decode #(
  parameter int SEL_W  = 3,
  parameter bit SINGLE = 1'b0,
  localparam int NPORT = 1 << SEL_W
) (
  input  logic             hit,
  input  logic [SEL_W-1:0] sel,
  output logic [NPORT-1:0] ce_n
);
  generate
    if (SINGLE) begin : g_one
      logic unused_sel;
      assign unused_sel = ^sel;
      always_comb begin
        ce_n    = '1;
        ce_n[0] = !hit;
      end
    end else begin : g_many
      for (genvar i = 0; i < NPORT; i++) begin : g_ce
        assign ce_n[i] = !(hit && (sel == SEL_W'(i)));
      end
    end
  endgenerate
endmodule

// File: rtl/mmio_rom_override.sv
module mmio_rom_override
  import mmio_dec_pkg::*;
#(
  parameter int NPORT = 8
) (
  input  logic [NPORT-1:0] ce_n,
  output rom_ovr_t         ovr
);
  always_comb begin
    ovr = ROM_OVR_IDLE;
    if (!(&ce_n)) ovr = '{en: 1'b1, val: 1'b1};
  end
endmodule

// File: rtl/mmio_port_decoder.sv
module mmio_port_decoder
  import mmio_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3,
  parameter int TAG_W  = 3,
  parameter logic [TAG_W-1:0] TAG = 3'b001,
  parameter bit SINGLE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_mreq_n,
  input  logic                    cpu_rd_n,
  input  logic                    cpu_wr_n,
  output logic [(1<<SEL_W)-1:0]   port_ce_n,
  output logic                    port_rd_n,
  output logic                    port_wr_n,
  output logic                    romcs_drive_en,
  output logic                    romcs_drive_val
);
  localparam int NPORT = 1 << SEL_W;
  localparam int MID_W = ADDR_W - TAG_W - SEL_W;

  logic             hit;
  logic [NPORT-1:0] ce_n_d;
  rom_ovr_t         ovr_d;
  logic             unused_mid;

  assign unused_mid = ^cpu_addr[SEL_W +: MID_W];

  mmio_hit_match #(.TAG_W(TAG_W), .TAG(TAG)) u_match (
    .tag_bits (cpu_addr[ADDR_W-1 -: TAG_W]),
    .mreq_n   (cpu_mreq_n),
    .hit      (hit)
  );

  mmio_sel_decode #(.SEL_W(SEL_W), .SINGLE(SINGLE)) u_sel (
    .hit  (hit),
    .sel  (cpu_addr[SEL_W-1:0]),
    .ce_n (ce_n_d)
  );

  mmio_rom_override #(.NPORT(NPORT)) u_ovr (
    .ce_n (ce_n_d),
    .ovr  (ovr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      port_ce_n       <= '1;
      port_rd_n       <= 1'b1;
      port_wr_n       <= 1'b1;
      romcs_drive_en  <= ROM_OVR_IDLE.en;
      romcs_drive_val <= ROM_OVR_IDLE.val;
    end else begin
      port_ce_n       <= ce_n_d;
      port_rd_n       <= cpu_rd_n;
      port_wr_n       <= cpu_wr_n;
      romcs_drive_en  <= ovr_d.en;
      romcs_drive_val <= ovr_d.val;
    end
  end
endmodule

// File: rtl/mmio_port_decoder_chk.sv
module mmio_port_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3,
  parameter int TAG_W  = 3,
  parameter logic [TAG_W-1:0] TAG = 3'b001,
  parameter bit SINGLE = 1'b0
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     cpu_addr,
  input logic                  cpu_mreq_n,
  input logic                  cpu_rd_n,
  input logic                  cpu_wr_n,
  input logic [(1<<SEL_W)-1:0] port_ce_n,
  input logic                  port_rd_n,
  input logic                  port_wr_n,
  input logic                  romcs_drive_en,
  input logic                  romcs_drive_val
);
  localparam int NPORT = 1 << SEL_W;
  logic bus_hit;
  assign bus_hit = !cpu_mreq_n && (cpu_addr[ADDR_W-1 -: TAG_W] == TAG);

  p_hit_one_r1: assert property (@(posedge clk) disable iff (rst)
    bus_hit |=> ($countones(~port_ce_n) == 1));

  p_miss_none_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_hit |=> (&port_ce_n));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~port_ce_n));

  p_ovr_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !(&port_ce_n) |-> (romcs_drive_en && romcs_drive_val));

  p_ovr_release_r6: assert property (@(posedge clk) disable iff (rst)
    (&port_ce_n) |-> !romcs_drive_en);

  p_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (port_rd_n == $past(cpu_rd_n) && port_wr_n == $past(cpu_wr_n)));

  generate
    if (SINGLE) begin : g_single
      p_single_r3: assert property (@(posedge clk) disable iff (rst)
        &port_ce_n[NPORT-1:1]);
    end else begin : g_eight
      p_sel_r2: assert property (@(posedge clk) disable iff (rst)
        bus_hit |=> !port_ce_n[$past(cpu_addr[SEL_W-1:0])]);
    end
  endgenerate
endmodule

bind mmio_port_decoder mmio_port_decoder_chk #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .TAG_W(TAG_W), .TAG(TAG), .SINGLE(SINGLE)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_mreq_n(cpu_mreq_n),
  .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .port_ce_n(port_ce_n),
  .port_rd_n(port_rd_n), .port_wr_n(port_wr_n),
  .romcs_drive_en(romcs_drive_en), .romcs_drive_val(romcs_drive_val)
);

// File: tb/mmio_port_decoder_bench.sv
module mmio_port_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  ce8_n, ce1_n;
  logic        rd8_n, wr8_n, en8, val8;
  logic        rd1_n, wr1_n, en1, val1;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  mmio_port_decoder u_mmio_port_decoder (
    .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_mreq_n(mreq_n),
    .cpu_rd_n(rd_n), .cpu_wr_n(wr_n), .port_ce_n(ce8_n),
    .port_rd_n(rd8_n), .port_wr_n(wr8_n),
    .romcs_drive_en(en8), .romcs_drive_val(val8));

  mmio_port_decoder #(.SINGLE(1'b1)) u_mmio_port_decoder_one (
    .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_mreq_n(mreq_n),
    .cpu_rd_n(rd_n), .cpu_wr_n(wr_n), .port_ce_n(ce1_n),
    .port_rd_n(rd1_n), .port_wr_n(wr1_n),
    .romcs_drive_en(en1), .romcs_drive_val(val1));

  // R1: hit = mreq low and addr[15:13] == 3'b001
  function automatic logic hit_of(logic [15:0] a, logic m);
    return !m && (a[15:13] == 3'b001);
  endfunction

  function automatic logic [7:0] ce_of(logic [15:0] a, logic m, bit single);
    logic [7:0] r = 8'hFF;
    if (hit_of(a, m)) begin
      if (single) r[0] = 1'b0;
      else r[a[2:0]] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h addr=%h mreq_n=%b", tag, act, exp, addr, mreq_n);
    end
  endtask

  task automatic check_all();
    logic [7:0] e8 = ce_of(addr, mreq_n, 1'b0);
    logic [7:0] e1 = ce_of(addr, mreq_n, 1'b1);
    chk(hit_of(addr, mreq_n) ? "R2 eight-port enable" : "R4 miss enables", 32'(ce8_n), 32'(e8));
    chk(hit_of(addr, mreq_n) ? "R3 single-port enable" : "R4 miss single", 32'(ce1_n), 32'(e1));
    chk((e8 != 8'hFF) ? "R5 override drive" : "R6 override release", 32'({en8, en8 ? val8 : 1'b1}), 32'({e8 != 8'hFF, 1'b1}));
    chk((e1 != 8'hFF) ? "R5 override single" : "R6 release single", 32'({en1, en1 ? val1 : 1'b1}), 32'({e1 != 8'hFF, 1'b1}));
    chk("R7 strobes", 32'({rd8_n, wr8_n, rd1_n, wr1_n}), 32'({rd_n, wr_n, rd_n, wr_n}));
  endtask

  // R8: inputs applied at a falling edge, results checked one clock later
  task automatic step(logic [15:0] a, logic m, logic r, logic w);
    addr = a; mreq_n = m; rd_n = r; wr_n = w;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // drive hit inputs during reset to show reset dominates (R8)
    addr = 16'h2003; mreq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset enables", 32'({ce8_n, ce1_n}), 32'h0000FFFF);
    chk("R8 reset strobes/override", 32'({rd8_n, wr8_n, en8, val8, en1, val1}), 32'b110101);
    rst = 1'b0;
    // R2 every port
    for (int i = 0; i < 8; i++) step(16'h2000 + 16'(i), 1'b0, i[0], !i[0]);
    // R1 negatives at same pattern
    step(16'h2005, 1'b1, 1'b0, 1'b1);  // mreq high
    step(16'h0005, 1'b0, 1'b0, 1'b1);  // bit13 low
    step(16'h6005, 1'b0, 1'b1, 1'b0);  // bit14 high
    step(16'hA005, 1'b0, 1'b1, 1'b0);  // bit15 high
    // R2 mirror, R3 any address in window
    step(16'h3FF9, 1'b0, 1'b0, 1'b1);
    step(16'h2006, 1'b0, 1'b1, 1'b0);
    step(16'h3FFF, 1'b0, 1'b1, 1'b1);
    step(16'h1FFF, 1'b0, 1'b1, 1'b1);
    // random, half biased into the window
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a = 16'($urandom);
      if ($urandom % 2) a[15:13] = 3'b001;
      step(a, 1'(($urandom % 4) == 0), 1'($urandom), 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule